// File: doc/BRIEF.md
# Reloadable Sub-Second Real-Time Clock

This block keeps time of day for a low-power domain. A 20-bit down-counting prescaler is advanced by one of two enable strobes: a crystal strobe divided by eight, or an RC oscillator strobe. Each time the prescaler passes through zero it emits a one-second tick and reloads from a value that software writes. Software picks that value so the tick falls once per second. The tick advances a seconds counter. The seconds counter carries into a minutes counter, and the minutes counter carries into an hours counter.

A tap selector picks which timing stage raises the wake/interrupt event. The stages are every prescaler step, every second, every new minute or every new hour. A sticky flag holds the event until software clears it. The whole block runs on one system clock. The oscillator sources arrive as single-cycle enable strobes, so the block generates no clocks of its own.

Top module: `subsec_rtc`

## Requirements
- R1: After reset, seconds, minutes, hours and the event flag are zero, the reload register holds the RST_RELOAD parameter, the source select is crystal (0) and the tap select is 0.
- R2: With reload value N held, a one-second tick occurs on every (N+1)-th prescaler enable, because the prescaler counts down and loads N when it steps while at 0. The seconds counter changes in the same clock edge as the enabling strobe.
- R3: With crystal source selected (control bit 0 = 0), every eighth xtal_en strobe is one prescaler enable, and rc_en has no effect on the time.
- R4: With RC source selected (control bit 0 = 1), every rc_en strobe is one prescaler enable, and xtal_en has no effect on the time.
- R5: A new reload value takes effect only at the next terminal count. The period already in progress finishes with the old length.
- R6: Seconds count up from 0 to 59, then wrap to 0 and advance the minutes.
- R7: Minutes count up from 0 to 59, then wrap to 0 and advance the hours, doing so only when the seconds wrap.
- R8: Hours count up from 0 to 23, then wrap to 0.
- R9: The tap select (control bits 2:1) picks the flag-setting event. 0 is every prescaler enable, 1 is every second tick, 2 is the seconds wrap (new minute) and 3 is the minutes wrap (new hour).
- R10: The event flag (evt_o, status bit 0) is sticky. Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged. A selected event in the same cycle as a clear leaves the flag set.
- R11: Register map on a 2-bit address. Address 0 is the reload value in bits 19:0. Address 1 is control: bit 0 source, bits 2:1 tap. Address 2 is status: bit 0 flag. Address 3 is the read-only time: seconds in bits 5:0, minutes in bits 13:8, hours in bits 20:16. Writes to address 3 are ignored, and unused read bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xtal_en | input | 1 | Crystal oscillator enable strobe, one cycle per crystal period |
| rc_en | input | 1 | RC oscillator enable strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data, combinational |
| sec_o | output | 6 | Seconds count |
| min_o | output | 6 | Minutes count |
| hr_o | output | 5 | Hours count |
| evt_o | output | 1 | Sticky wake/interrupt flag |

## Verification
The hardest states to reach are the hour rollovers: the 22-to-23 step and midnight. Reaching them takes tens of thousands of seconds. The bench sets the reload to zero and selects the RC source, then holds rc_en high continuously so that every clock is one second. This carries the time to 22:59:59 and later to 23:59:59 in under ninety thousand cycles. A cycle-level model in the bench tracks the expected counts along the way. The set-wins-over-clear corner is reached by one write that lands in the same cycle as an RC strobe.

// File: rtl/subsec_rtc_pkg.sv
package subsec_rtc_pkg;
    localparam int SEC_W  = 6;
    localparam int MIN_W  = 6;
    localparam int HR_W   = 5;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;
    localparam int NTAP   = 4;

    typedef enum logic [ADDR_W-1:0] {
        ADR_RELOAD = 2'd0,
        ADR_CTRL   = 2'd1,
        ADR_STATUS = 2'd2,
        ADR_TIME   = 2'd3
    } rtc_addr_e;

    typedef enum logic [1:0] {
        TAP_STEP   = 2'd0,
        TAP_SECOND = 2'd1,
        TAP_MINUTE = 2'd2,
        TAP_HOUR   = 2'd3
    } rtc_tap_e;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int              CNT_W      = 20,
    parameter int              DIV_LOG2   = 3,
    parameter logic [CNT_W-1:0] RST_RELOAD = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xtal_en,
    input  logic             rc_en,
    input  logic             src_rc,
    input  logic [CNT_W-1:0] reload,
    output logic             src_en,
    output logic             tick
);
    logic             xtal_step;
    logic [CNT_W-1:0] cnt_d, cnt_q;

    // Crystal divider: a variant picked by the divide parameter
    generate
        if (DIV_LOG2 == 0) begin : g_nodiv
            assign xtal_step = xtal_en;
        end else begin : g_div
            logic [DIV_LOG2-1:0] div_d, div_q;
            always_comb begin
                div_d = div_q;
                if (xtal_en) div_d = div_q + DIV_LOG2'(1);
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) div_q <= '0;
                else        div_q <= div_d;
            end
            assign xtal_step = xtal_en && (div_q == '1);
        end
    endgenerate

    always_comb begin
        src_en = src_rc ? rc_en : xtal_step;
        tick   = src_en && (cnt_q == '0);
        cnt_d  = cnt_q;
        if (src_en) begin
            if (cnt_q == '0) cnt_d = reload;
            else             cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= RST_RELOAD;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rtc_wrap_counter.sv
module rtc_wrap_counter #(
    parameter int          W    = 6,
    parameter int unsigned LAST = 59
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] val,
    output logic         carry
);
    logic [W-1:0] val_d, val_q;

    always_comb begin
        carry = inc && (val_q == W'(LAST));
        val_d = val_q;
        if (inc) val_d = carry ? '0 : val_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign val = val_q;
endmodule

// File: rtl/rtc_event_sel.sv
module rtc_event_sel #(
    parameter int NTAP  = 4,
    parameter int SEL_W = $clog2(NTAP)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTAP-1:0]  ev,
    input  logic [SEL_W-1:0] sel,
    input  logic             clr,
    output logic             flag
);
    logic hit;
    logic flag_d, flag_q;

    always_comb begin
        hit    = ev[sel];
        flag_d = flag_q;
        if (clr) flag_d = 1'b0;
        if (hit) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;
endmodule

// File: rtl/subsec_rtc.sv
module subsec_rtc
    import subsec_rtc_pkg::*;
#(
    parameter int               CNT_W      = 20,
    parameter int               DIV_LOG2   = 3,
    parameter logic [CNT_W-1:0] RST_RELOAD = CNT_W'(4095)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xtal_en,
    input  logic              rc_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [SEC_W-1:0]  sec_o,
    output logic [MIN_W-1:0]  min_o,
    output logic [HR_W-1:0]   hr_o,
    output logic              evt_o
);
    typedef struct packed {
        logic [CNT_W-1:0] reload;
        logic             src_rc;
        logic [1:0]       tap;
    } cfg_t;

    cfg_t            cfg_d, cfg_q;
    logic            src_en, tick, sec_carry, min_carry, hr_carry, status_clr;
    logic [NTAP-1:0] ev_vec;

    always_comb begin
        cfg_d      = cfg_q;
        status_clr = 1'b0;
        if (wr_en) begin
            case (rtc_addr_e'(wr_addr))
                ADR_RELOAD: cfg_d.reload = wr_data[CNT_W-1:0];
                ADR_CTRL: begin
                    cfg_d.src_rc = wr_data[0];
                    cfg_d.tap    = wr_data[2:1];
                end
                ADR_STATUS: status_clr = wr_data[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '{reload: RST_RELOAD, src_rc: 1'b0, tap: 2'd0};
        else        cfg_q <= cfg_d;
    end

    rtc_prescaler #(.CNT_W(CNT_W), .DIV_LOG2(DIV_LOG2), .RST_RELOAD(RST_RELOAD)) u_pre (
        .clk(clk), .rst_n(rst_n), .xtal_en(xtal_en), .rc_en(rc_en),
        .src_rc(cfg_q.src_rc), .reload(cfg_q.reload), .src_en(src_en), .tick(tick)
    );

    rtc_wrap_counter #(.W(SEC_W), .LAST(59)) u_sec (
        .clk(clk), .rst_n(rst_n), .inc(tick), .val(sec_o), .carry(sec_carry)
    );
    rtc_wrap_counter #(.W(MIN_W), .LAST(59)) u_min (
        .clk(clk), .rst_n(rst_n), .inc(sec_carry), .val(min_o), .carry(min_carry)
    );
    rtc_wrap_counter #(.W(HR_W), .LAST(23)) u_hr (
        .clk(clk), .rst_n(rst_n), .inc(min_carry), .val(hr_o), .carry(hr_carry)
    );

    assign ev_vec = {min_carry, sec_carry, tick, src_en};

    rtc_event_sel #(.NTAP(NTAP)) u_evt (
        .clk(clk), .rst_n(rst_n), .ev(ev_vec), .sel(cfg_q.tap),
        .clr(status_clr), .flag(evt_o)
    );

    always_comb begin
        rd_data = '0;
        case (rtc_addr_e'(rd_addr))
            ADR_RELOAD: rd_data[CNT_W-1:0] = cfg_q.reload;
            ADR_CTRL:   rd_data[2:0]       = {cfg_q.tap, cfg_q.src_rc};
            ADR_STATUS: rd_data[0]         = evt_o;
            default:    rd_data = {11'd0, hr_o, 2'd0, min_o, 2'd0, sec_o};
        endcase
    end
endmodule

// File: rtl/subsec_rtc_chk.sv
module subsec_rtc_chk
    import subsec_rtc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [1:0]        tap,
    input logic [NTAP-1:0]   ev,
    input logic              tick,
    input logic [SEC_W-1:0]  sec_o,
    input logic [MIN_W-1:0]  min_o,
    input logic [HR_W-1:0]   hr_o,
    input logic              evt_o
);
    localparam logic [SEC_W-1:0] SEC_LAST = 6'd59;
    localparam logic [MIN_W-1:0] MIN_LAST = 6'd59;
    localparam logic [HR_W-1:0]  HR_LAST  = 5'd23;

    logic w1c, tap_hit;
    assign w1c     = wr_en && (wr_addr == ADR_STATUS) && wr_data[0];
    assign tap_hit = ev[tap];

    // R6
    sec_range_chk: assert property (@(posedge clk) disable iff (!rst_n) sec_o <= SEC_LAST);
    // R7
    min_range_chk: assert property (@(posedge clk) disable iff (!rst_n) min_o <= MIN_LAST);
    // R8
    hr_range_chk: assert property (@(posedge clk) disable iff (!rst_n) hr_o <= HR_LAST);
    // R6
    sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sec_o) |-> sec_o == (($past(sec_o) == SEC_LAST) ? '0 : $past(sec_o) + SEC_W'(1)));
    // R7
    min_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(min_o) |-> (sec_o == '0) && ($past(sec_o) == SEC_LAST));
    // R2
    tick_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !$stable(sec_o));
    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c && !tap_hit) |=> !evt_o);
    // R10
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o && !w1c) |=> evt_o);
    // R9
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_o) |-> $past(tap_hit));
endmodule

bind subsec_rtc subsec_rtc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tap(cfg_q.tap), .ev(ev_vec), .tick(tick), .sec_o(sec_o), .min_o(min_o),
    .hr_o(hr_o), .evt_o(evt_o)
);

// File: tb/subsec_rtc_test.sv
module subsec_rtc_test;
    localparam int CLK_PERIOD = 10;
    localparam int RST_RL     = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xtal_en = 1'b0, rc_en = 1'b0, wr_en = 1'b0;
    logic [1:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [5:0]  sec_o, min_o;
    logic [4:0]  hr_o;
    logic        evt_o;

    int checks = 0, fails = 0;
    bit done = 0;

    // bench model of the time and flag
    int m_div = 0, m_cnt = RST_RL, m_reload = RST_RL, m_src = 0, m_tap = 0;
    int m_sec = 0, m_min = 0, m_hr = 0, m_flag = 0;

    subsec_rtc #(.RST_RELOAD(20'(RST_RL))) uut (
        .clk(clk), .rst_n(rst_n), .xtal_en(xtal_en), .rc_en(rc_en),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .sec_o(sec_o), .min_o(min_o), .hr_o(hr_o), .evt_o(evt_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_step();
        bit ev_s, ev_m, ev_h;
        ev_s = 0; ev_m = 0; ev_h = 0;
        if (m_cnt == 0) begin
            m_cnt = m_reload;
            ev_s = 1;
            if (m_sec == 59) begin
                m_sec = 0; ev_m = 1;
                if (m_min == 59) begin
                    m_min = 0; ev_h = 1;
                    m_hr = (m_hr == 23) ? 0 : m_hr + 1;
                end else m_min++;
            end else m_sec++;
        end else m_cnt--;
        if (m_tap == 0 || (m_tap == 1 && ev_s) || (m_tap == 2 && ev_m) || (m_tap == 3 && ev_h))
            m_flag = 1;
    endtask

    task automatic rc_run(input int n);
        @(negedge clk); rc_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (m_src == 1) model_step();
        end
        rc_en = 1'b0;
    endtask

    task automatic xtal_run(input int n);
        @(negedge clk); xtal_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            m_div = (m_div + 1) % 8;
            if (m_div == 0 && m_src == 0) model_step();
        end
        xtal_en = 1'b0;
    endtask

    task automatic wr(input int a, input int d, input bit with_rc);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'(a); wr_data = 32'(d); rc_en = with_rc;
        @(negedge clk);
        wr_en = 1'b0; rc_en = 1'b0;
        case (a)
            0: m_reload = d & 32'hFFFFF;
            1: begin m_src = d & 1; m_tap = (d >> 1) & 3; end
            2: if (d & 1) m_flag = 0;
            default: ;
        endcase
        if (with_rc && m_src == 1) model_step();
    endtask

    task automatic rd(input int a, output int v);
        rd_addr = 2'(a);
        #1 v = int'(rd_data);
    endtask

    task automatic check_time(input string req);
        int v;
        chk({req, " sec"}, int'(sec_o), m_sec);
        chk({req, " min"}, int'(min_o), m_min);
        chk({req, " hr"},  int'(hr_o),  m_hr);
        rd(3, v);
        chk({req, " time reg"}, v, (m_hr << 16) | (m_min << 8) | m_sec);
    endtask

    task automatic t_reset();
        int v;
        rd(0, v); chk("R1 reload", v, RST_RL);
        rd(1, v); chk("R1 ctrl", v, 0);
        rd(2, v); chk("R1 status", v, 0);
        chk("R1 flag", int'(evt_o), 0);
        check_time("R1");
    endtask

    task automatic t_crystal();
        rc_run(30);                 // ignored under crystal source
        check_time("R3 rc ignored");
        xtal_run(79);               // 9 enables + 7 strobes: no tick yet
        check_time("R2 R3 before tick");
        chk("R3 still zero", int'(sec_o), 0);
        xtal_run(1);                // 10th enable
        check_time("R2 R3 tick");
        chk("R2 first second", int'(sec_o), 1);
    endtask

    task automatic t_rc();
        wr(1, 1, 0);                // RC source, tap 0
        xtal_run(50);
        check_time("R4 xtal ignored");
        rc_run(9);
        chk("R4 no tick yet", int'(sec_o), 1);
        rc_run(1);
        chk("R4 rc tick", int'(sec_o), 2);
        check_time("R4");
    endtask

    task automatic t_reload();
        wr(0, 3, 0);                // current period of 10 still runs
        rc_run(9);
        chk("R5 old period holds", int'(sec_o), 2);
        rc_run(1);
        chk("R5 old period ends", int'(sec_o), 3);
        rc_run(3);
        chk("R5 new period partial", int'(sec_o), 3);
        rc_run(1);
        chk("R5 new period of 4", int'(sec_o), 4);
        check_time("R5");
        wr(0, 0, 0);
        rc_run(4);
        check_time("R2 reload zero");
        rc_run(1);
        check_time("R2 every enable");
    endtask

    task automatic t_flag();
        int v;
        wr(2, 1, 0);
        chk("R10 w1c clears", int'(evt_o), 0);
        rc_run(1);
        chk("R9 tap0 sets", int'(evt_o), 1);
        wr(2, 0, 0);
        chk("R10 write zero keeps", int'(evt_o), 1);
        wr(2, 1, 1);
        chk("R10 set wins", int'(evt_o), 1);
        rd(2, v); chk("R11 status read", v, 1);
        wr(2, 1, 0);
        chk("R10 cleared", int'(evt_o), m_flag);
    endtask

    task automatic t_tap_second();
        int v;
        wr(0, 1, 0);
        wr(1, 3, 0);                // RC, tap 1
        rd(1, v); chk("R11 ctrl read", v, 3);
        rc_run(1);                  // counter at 0: tick, reload 1
        chk("R9 tap1 on tick", int'(evt_o), 1);
        wr(2, 1, 0);
        rc_run(1);                  // 1 -> 0, no tick
        chk("R9 tap1 quiet without tick", int'(evt_o), 0);
        rc_run(1);
        chk("R9 tap1 second tick", int'(evt_o), 1);
        check_time("R9 tap1");
        wr(0, 0, 0);
        rc_run(2);
        check_time("R2 back to zero reload");
    endtask

    task automatic t_minute();
        wr(1, 5, 0);                // RC, tap 2
        wr(2, 1, 0);
        rc_run(59 - m_sec);
        check_time("R6 at 59");
        chk("R9 tap2 quiet", int'(evt_o), 0);
        rc_run(1);
        check_time("R6 wrap");
        chk("R7 minute one", int'(min_o), 1);
        chk("R9 tap2 on minute", int'(evt_o), 1);
    endtask

    task automatic t_hour();
        int now, tgt, v;
        wr(1, 7, 0);                // RC, tap 3
        now = m_hr * 3600 + m_min * 60 + m_sec;
        tgt = 22 * 3600 + 59 * 60 + 59;
        rc_run(tgt - now);
        check_time("R7 22:59:59");
        wr(2, 1, 0);
        chk("R10 cleared before hour", int'(evt_o), 0);
        rc_run(1);
        check_time("R7 hour carry");
        chk("R8 hour 23", int'(hr_o), 23);
        chk("R9 tap3 on hour", int'(evt_o), 1);
        rc_run(3599);
        check_time("R8 23:59:59");
        rc_run(1);
        check_time("R8 midnight");
        chk("R8 hr wraps", int'(hr_o), 0);
        wr(3, 32'h0015_3B3B, 0);
        check_time("R11 time write ignored");
        rd(0, v); chk("R11 reload read", v, m_reload);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_crystal();
        t_rc();
        t_reload();
        t_flag();
        t_tap_second();
        t_minute();
        t_hour();
        if (!done) begin
            done = 1;
            summary();
            $finish;
        end
    end
endmodule